// File: doc/BRIEF.md
# RMII Receive Deserializer (MAC side)

This block sits on the MAC side of a reduced media-independent interface. It takes the receive pins from the PHY on the 50 MHz reference clock: a carrier/data-valid line with no fixed timing against that clock, a receive-error line and a two-bit data pair. From these it builds a stream of bytes for the MAC. The carrier line is synchronized first. The data pair and the error line pass through the same number of register stages, so all three stay aligned.

Once carrier is seen, the block skips the 00 dibits the PHY sends while its decoder settles. It waits for the first 01 dibit and then shifts dibits in, least significant first, until the last four form the start-frame delimiter 0xD5. From then on every four dibits make one byte. Each byte is held back until the next one completes, so the final byte can carry the end-of-frame marker and the error flags when carrier drops.

A speed input selects sampling on every clock (100 Mbps) or once every ten clocks (10 Mbps). For half-duplex use, a collision output is also regenerated from the local transmitter's enable and the synchronized carrier.

Top module: `rmii_rx_deser`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid`, `out_last`, `out_err`, `out_align_err` and `col` are all 0.
- R2: `crs_dv` is synchronized through `SYNC_STAGES` flops, and `rxd` and `rx_er` are delayed by the same count. The byte that carries `out_last` appears `SYNC_STAGES+1` clocks after `crs_dv` falls (3 clocks by default).
- R3: After carrier rises, dibits of value 00 are discarded until the first dibit of value 01 arrives. Any number of leading 00 dibits gives the same output.
- R4: Preamble and delimiter dibits are never output. Bytes start right after the last four dibits, packed LSB first (first dibit into bits 1:0), equal 0xD5. A frame whose preamble never forms 0xD5 produces no output.
- R5: At 100 Mbps (`speed_10`=0), one dibit is taken on every clock while the synchronized carrier is high.
- R6: At 10 Mbps (`speed_10`=1), one dibit is taken every `SLOW_DIV` clocks (default 10). The sample falls at offset `SLOW_DIV/2` from the synchronized carrier rise, so a dibit held for ten clocks is read once, mid-window.
- R7: While `crs_dv` is low, the data pair (00 for idle, 01 for low-power idle) is ignored and `out_valid` stays 0.
- R8: If `rx_er` is high for any clock while carrier is high, anywhere in the frame including the preamble, `out_err` is 1 on that frame's last byte. It is 0 on every byte that is not last and 0 on clean frames.
- R9: If carrier falls with 1 to 3 dibits of an unfinished byte, those dibits are dropped and `out_align_err` is 1 on the last whole byte. Otherwise it is 0.
- R10: Every whole data byte is output exactly once, in order, as a one-clock `out_valid` pulse. Exactly the final byte has `out_last`=1.
- R11: `col` is the registered AND of `tx_en` and the synchronized carrier. It follows `tx_en` one clock later and `crs_dv` `SYNC_STAGES+1` clocks later.
- R12: A frame that ends before one whole data byte follows the delimiter produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (50 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| speed_10 | input | 1 | 1 = 10 Mbps sampling, 0 = 100 Mbps |
| crs_dv | input | 1 | Carrier sense / data valid from PHY, asynchronous rise |
| rx_er | input | 1 | Receive symbol error from PHY |
| rxd | input | 2 | Receive dibit from PHY |
| tx_en | input | 1 | Local transmitter enable, used for collision |
| out_valid | output | 1 | Byte strobe, one clock per byte |
| out_data | output | 8 | Received byte |
| out_last | output | 1 | Marks the final byte of a frame |
| out_err | output | 1 | Frame saw a receive error (with out_last) |
| out_align_err | output | 1 | Frame ended mid-byte (with out_last) |
| col | output | 1 | Regenerated collision indication |

## Verification
The final byte of a frame is due three clocks after the bench drops carrier: two synchronizer stages plus the output register. The bench takes the cycle count at the drop and at the `out_last` pulse and compares the difference against that exact value. Earlier bytes only come out when the byte after them completes, so the bench gathers every `out_valid` pulse between frames and compares the whole ordered list with bytes it computes from the frame's seed. Collision is sampled at precise offsets: it must still be low two clocks after carrier rises and high on the third, and it must clear one clock after `tx_en` drops.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

  typedef enum logic [1:0] {
    FR_HUNT = 2'd0,
    FR_PRE  = 2'd1,
    FR_DATA = 2'd2
  } fr_state_e;

  localparam logic [7:0] SFD_BYTE   = 8'hD5;
  localparam logic [1:0] LEAD_DIBIT = 2'b01;

endpackage

// File: rtl/rmii_rx_sync.sv
module rmii_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       crs_in,
  input  logic       er_in,
  input  logic [1:0] rxd_in,
  output logic       crs_s,
  output logic       er_s,
  output logic [1:0] rxd_s
);

  logic [STAGES-1:0]      crs_pipe;
  logic [STAGES-1:0]      er_pipe;
  logic [STAGES-1:0][1:0] rxd_pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      crs_pipe <= '0;
      er_pipe  <= '0;
      rxd_pipe <= '0;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) begin
        crs_pipe[i] <= crs_pipe[i-1];
        er_pipe[i]  <= er_pipe[i-1];
        rxd_pipe[i] <= rxd_pipe[i-1];
      end
      crs_pipe[0] <= crs_in;
      er_pipe[0]  <= er_in;
      rxd_pipe[0] <= rxd_in;
    end
  end

  assign crs_s = crs_pipe[STAGES-1];
  assign er_s  = er_pipe[STAGES-1];
  assign rxd_s = rxd_pipe[STAGES-1];

endmodule

// File: rtl/rmii_rx_strobe.sv
module rmii_rx_strobe #(
  parameter int SLOW_DIV = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic slow,
  input  logic crs_s,
  output logic strobe
);

  localparam int CNT_W     = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam int SAMPLE_AT = SLOW_DIV / 2;
  localparam int LAST_CNT  = SLOW_DIV - 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !crs_s) begin
      cnt <= '0;
    end else if (cnt == CNT_W'(LAST_CNT)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign strobe = crs_s && (!slow || (cnt == CNT_W'(SAMPLE_AT)));

  // slow mode never samples on two neighbouring clocks
  AST_SLOW_SPACING: assert property (@(posedge clk) disable iff (rst)
    (slow && $past(slow) && strobe) |-> !$past(strobe)); // R6

endmodule

// File: rtl/rmii_rx_framer.sv
module rmii_rx_framer
  import rmii_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       strobe,
  input  logic       crs_s,
  input  logic       er_s,
  input  logic [1:0] dibit,
  output logic       o_valid,
  output logic [7:0] o_data,
  output logic       o_last,
  output logic       o_err,
  output logic       o_align
);

  fr_state_e  state;
  logic [7:0] sreg;
  logic [7:0] sr_nxt;
  logic [1:0] dib_cnt;
  logic [7:0] pend;
  logic       pend_v;
  logic       er_seen;
  logic       crs_d;
  logic       end_evt;

  assign sr_nxt  = {dibit, sreg[7:2]};
  assign end_evt = crs_d && !crs_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= FR_HUNT;
      sreg    <= '0;
      dib_cnt <= '0;
      pend    <= '0;
      pend_v  <= 1'b0;
      er_seen <= 1'b0;
      crs_d   <= 1'b0;
      o_valid <= 1'b0;
      o_data  <= '0;
      o_last  <= 1'b0;
      o_err   <= 1'b0;
      o_align <= 1'b0;
    end else begin
      crs_d   <= crs_s;
      o_valid <= 1'b0;
      o_last  <= 1'b0;
      o_err   <= 1'b0;
      o_align <= 1'b0;
      if (crs_s && er_s) begin
        er_seen <= 1'b1;
      end
      if (end_evt) begin
        if (pend_v) begin
          o_valid <= 1'b1;
          o_data  <= pend;
          o_last  <= 1'b1;
          o_err   <= er_seen;
          o_align <= (state == FR_DATA) && (dib_cnt != 2'd0);
        end
        state   <= FR_HUNT;
        sreg    <= '0;
        dib_cnt <= '0;
        pend_v  <= 1'b0;
        er_seen <= 1'b0;
      end else if (strobe) begin
        case (state)
          FR_HUNT: begin
            if (dibit == LEAD_DIBIT) begin
              state <= FR_PRE;
              sreg  <= {LEAD_DIBIT, 6'b0};
            end
          end
          FR_PRE: begin
            sreg <= sr_nxt;
            if (sr_nxt == SFD_BYTE) begin
              state   <= FR_DATA;
              dib_cnt <= '0;
            end
          end
          FR_DATA: begin
            sreg    <= sr_nxt;
            dib_cnt <= dib_cnt + 2'd1;
            if (dib_cnt == 2'd3) begin
              if (pend_v) begin
                o_valid <= 1'b1;
                o_data  <= pend;
              end
              pend   <= sr_nxt;
              pend_v <= 1'b1;
            end
          end
          default: state <= FR_HUNT;
        endcase
      end
    end
  end

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    o_last |-> o_valid); // R10
  AST_FLAGS_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    (o_err || o_align) |-> o_last); // R8
  AST_QUIET_NO_CARRIER: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> ($past(crs_s) || $past(crs_s, 2))); // R7
  AST_ERR_CAPTURED: assert property (@(posedge clk) disable iff (rst)
    $past(crs_s && er_s) |-> er_seen); // R8

endmodule

// File: rtl/rmii_rx_deser.sv
module rmii_rx_deser #(
  parameter int SYNC_STAGES = 2,
  parameter int SLOW_DIV    = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       speed_10,
  input  logic       crs_dv,
  input  logic       rx_er,
  input  logic [1:0] rxd,
  input  logic       tx_en,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last,
  output logic       out_err,
  output logic       out_align_err,
  output logic       col
);

  logic       crs_s;
  logic       er_s;
  logic [1:0] rxd_s;
  logic       strobe;

  rmii_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .crs_in (crs_dv),
    .er_in  (rx_er),
    .rxd_in (rxd),
    .crs_s  (crs_s),
    .er_s   (er_s),
    .rxd_s  (rxd_s)
  );

  rmii_rx_strobe #(.SLOW_DIV(SLOW_DIV)) u_strobe (
    .clk    (clk),
    .rst    (rst),
    .slow   (speed_10),
    .crs_s  (crs_s),
    .strobe (strobe)
  );

  rmii_rx_framer u_framer (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .crs_s   (crs_s),
    .er_s    (er_s),
    .dibit   (rxd_s),
    .o_valid (out_valid),
    .o_data  (out_data),
    .o_last  (out_last),
    .o_err   (out_err),
    .o_align (out_align_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col <= 1'b0;
    end else begin
      col <= tx_en && crs_s;
    end
  end

  AST_COL_REGEN: assert property (@(posedge clk) disable iff (rst)
    col == ($past(tx_en) && $past(crs_s))); // R11
  AST_COL_NEEDS_TX: assert property (@(posedge clk) disable iff (rst)
    !$past(tx_en) |-> !col); // R11

endmodule

// File: tb/sim_rmii_rx_deser.sv
module sim_rmii_rx_deser;

  localparam int CLK_PERIOD = 20;
  localparam int SYNC_LAT   = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       speed_10 = 1'b0;
  logic       crs_dv = 1'b0;
  logic       rx_er = 1'b0;
  logic [1:0] rxd = 2'b00;
  logic       tx_en = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_last;
  logic       out_err;
  logic       out_align_err;
  logic       col;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int ng = 0;
  logic [7:0] g_data [1024];
  logic       g_last [1024];
  logic       g_err  [1024];
  logic       g_aln  [1024];
  int         g_cyc  [1024];

  rmii_rx_deser u0 (
    .clk(clk), .rst(rst), .speed_10(speed_10), .crs_dv(crs_dv),
    .rx_er(rx_er), .rxd(rxd), .tx_en(tx_en), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .out_err(out_err),
    .out_align_err(out_align_err), .col(col)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (!rst && out_valid && ng < 1024) begin
      g_data[ng] = out_data;
      g_last[ng] = out_last;
      g_err[ng]  = out_err;
      g_aln[ng]  = out_align_err;
      g_cyc[ng]  = cyc;
      ng++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dbyte(input int seed, input int b);
    return 8'((seed * 29 + b * 71 + 3) & 255);
  endfunction

  // erk: 0 none, 1 in preamble, 2 on last dibit. nosfd: preamble never forms 0xD5.
  task automatic run_frame(input bit slow, input int nz, input int nb,
                           input int ex, input int erk, input int seed,
                           input bit nosfd);
    int dq[$];
    bit eq[$];
    int hold;
    int base;
    int drop_cyc;
    int expn;
    hold = slow ? 10 : 1;
    speed_10 = slow;
    repeat (3) @(negedge clk);
    for (int i = 0; i < nz; i++) dq.push_back(0);
    for (int i = 0; i < 28; i++) dq.push_back(1);
    if (nosfd) begin
      for (int i = 0; i < 4; i++) dq.push_back(1);
    end else begin
      dq.push_back(1); dq.push_back(1); dq.push_back(1); dq.push_back(3);
    end
    for (int b = 0; b < nb; b++)
      for (int k = 0; k < 4; k++) dq.push_back(int'((dbyte(seed, b) >> (2*k)) & 8'd3));
    for (int k = 0; k < ex; k++) dq.push_back((k + 2) & 3);
    for (int i = 0; i < dq.size(); i++) eq.push_back(1'b0);
    if (erk == 1) eq[nz + 5] = 1'b1;
    if (erk == 2) eq[dq.size() - 1] = 1'b1;
    base = ng;
    for (int i = 0; i < dq.size(); i++) begin
      crs_dv = 1'b1;
      rxd = 2'(dq[i]);
      rx_er = eq[i];
      repeat (hold) @(negedge clk);
    end
    crs_dv = 1'b0;
    rxd = 2'b00;
    rx_er = 1'b0;
    drop_cyc = cyc;
    repeat (12) @(negedge clk);
    expn = nosfd ? 0 : nb;
    if (nosfd) chk("R4 no-delimiter frame byte count", ng - base, 0);
    else if (nb == 0) chk("R12 empty frame byte count", ng - base, 0);
    else chk("R10 byte count", ng - base, expn);
    if (ng - base == expn) begin
      for (int i = 0; i < expn; i++) begin
        chk(slow ? "R6 data byte (10M)" : "R5 data byte (100M)",
            int'(g_data[base+i]), int'(dbyte(seed, i)));
        chk("R10 last marker", int'(g_last[base+i]), (i == expn-1) ? 1 : 0);
        chk("R8 error flag", int'(g_err[base+i]), (i == expn-1 && erk != 0) ? 1 : 0);
        chk("R9 alignment flag", int'(g_aln[base+i]), (i == expn-1 && ex != 0) ? 1 : 0);
      end
      if (expn > 0)
        chk("R2 last byte latency", g_cyc[base+expn-1] - drop_cyc, SYNC_LAT);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    int seed;
    int base;
    seed = 1;
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", int'(out_valid), 0);
    chk("R1 col in reset", int'(col), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 out_last after reset", int'(out_last), 0);
    chk("R1 out_err after reset", int'(out_err), 0);
    chk("R1 out_align_err after reset", int'(out_align_err), 0);

    // idle and low-power idle with carrier low
    base = ng;
    rxd = 2'b01;
    repeat (60) @(negedge clk);
    rxd = 2'b00;
    repeat (20) @(negedge clk);
    chk("R7 idle codes give no bytes", ng - base, 0);

    // sweep of speed, leading zeros (R3), length, tail and error placement
    for (int s = 0; s < 2; s++)
      for (int nz = 0; nz < 3; nz++)
        for (int nb = 1; nb < 4; nb++)
          for (int ex = 0; ex < 4; ex++) begin
            run_frame(s[0], nz, nb, ex, (nz + nb + ex) % 3, seed, 1'b0);
            seed++;
          end

    run_frame(1'b0, 2, 0, 2, 0, seed, 1'b0);  // R12
    run_frame(1'b1, 0, 0, 3, 1, seed, 1'b0);  // R12
    run_frame(1'b0, 1, 3, 0, 0, seed, 1'b1);  // R4

    // collision regeneration
    speed_10 = 1'b0;
    tx_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 col with tx only", int'(col), 0);
    crs_dv = 1'b1;
    rxd = 2'b00;
    repeat (2) @(negedge clk);
    chk("R11 col before sync done", int'(col), 0);
    @(negedge clk);
    chk("R11 col after sync", int'(col), 1);
    tx_en = 1'b0;
    @(negedge clk);
    chk("R11 col follows tx_en drop", int'(col), 0);
    crs_dv = 1'b0;
    repeat (10) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

endmodule